// File: doc/BRIEF.md
# Length-Salted Pearson Token Hasher

This block sits between a tokenizer and a bank of Bloom filters. It accepts a byte stream, one byte per cycle, in which each token is bracketed by a start flag on its first byte and an end flag on its last byte. For every token it produces several independent 32-bit hash words that the filters downstream use as indices. Each word is assembled from four 8-bit Pearson lanes, and each lane owns a pseudo-random 256-entry permutation table.

Short tokens give very few table lookups, so two tokens that differ mainly in length could share a hash. To separate them, the block counts the bytes of each token and feeds that count through every lane as two extra bytes, high byte first, after the token ends. During those two cycles it refuses input, so a stream of C bytes in T tokens runs at C/(C+2T) of the byte rate. The hash words are presented with a single-cycle valid pulse once the second length byte has been absorbed.

Top module: `tokhash_pearson`

## Requirements
- R1: While reset is held, and in the first cycle after it, in_ready is 1 and out_valid is 0.
- R2: Lane k (k = 0 .. 4·NUM_HASH−1) holds an 8-bit state. Output word j is out_hash[32j+31:32j], with lane 4j in bits 7:0, lane 4j+1 in bits 15:8, lane 4j+2 in bits 23:16 and lane 4j+3 in bits 31:24. An accepted token byte b moves lane k from state s to T_k(s XOR b). On a byte with in_first set, s is replaced by the lane's start value I_k = (SEED XOR (29k+7)) mod 256.
- R3: T_k(x) is computed as follows: S = (SEED+53k) mod 256; M = (2·(⌊SEED/2⌋+19k)+1) mod 256; a = ((x XOR S)·M) mod 256; c = a XOR ⌊a/8⌋; T_k(x) = (167·c+71k+3) mod 256. The default SEED is 0x5A.
- R4: After the token's last byte, every lane absorbs the token length (the number of accepted bytes of the token) as two further bytes through T_k, the high byte first and then the low byte.
- R5: When a byte with in_last set is accepted, in_ready is 0 in exactly the two cycles that follow and is 1 again in the third.
- R6: out_valid is 1 for exactly one cycle. That cycle is the third one after the cycle in which the last byte was accepted. During that cycle out_hash carries the final hash words of that token.
- R7: A byte with in_first set that arrives while a token is open discards the partial token and starts a new token from that byte.
- R8: A byte presented with in_valid set while no token is open and in_first is clear is ignored, and it does not change any later hash.
- R9: The length counter is 16 bits and wraps. A token of 65537 bytes is salted with the length 1.
- R10: Cycles with in_valid low inside a token leave the lane states and the length unchanged.
- R11: A byte with both in_first and in_last set is a complete token of length 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | in_byte carries a token byte |
| in_byte | input | 8 | Token byte |
| in_first | input | 1 | Byte opens a token |
| in_last | input | 1 | Byte closes a token |
| in_ready | output | 1 | Byte is accepted when in_valid and in_ready are both 1 |
| out_valid | output | 1 | Single-cycle pulse: out_hash holds a finished token's words |
| out_hash | output | 32·NUM_HASH | Hash word j in bits 32j+31:32j |

## Verification
Counting from the cycle in which a closing byte is accepted, in_ready goes low in the next two cycles and out_valid with the finished words follows in the third. The bench's reference model steps once per clock edge with exactly this schedule. It compares in_ready, out_valid and, in a valid cycle, every hash bit at the falling edge before the next inputs are applied, so each result is checked in the one cycle in which it is due and in no other. Gaps, restarts, stray bytes and the 16-bit wrap are applied through the same cycle-by-cycle drive, so a result that is early, late or missing shows up as a mismatch in a specific cycle.

// File: rtl/tokhash_pkg.sv
package tokhash_pkg;

   // Permutation entry of the table that belongs to lane `lane`.
   function automatic logic [7:0] pearson_entry(input int lane, input int seed,
                                                input logic [7:0] x);
      int s_k, m_k, t1, t2, t3;
      s_k = (seed + 53 * lane) & 255;
      m_k = ((((seed >> 1) + 19 * lane) << 1) | 1) & 255;
      t1  = ((int'(x) ^ s_k) * m_k) & 255;
      t2  = t1 ^ (t1 >> 3);
      t3  = (t2 * 167 + 71 * lane + 3) & 255;
      return t3[7:0];
   endfunction

   // Value a lane starts from when a token opens.
   function automatic logic [7:0] lane_init(input int lane, input int seed);
      int v;
      v = (seed ^ (29 * lane + 7)) & 255;
      return v[7:0];
   endfunction

endpackage

// File: rtl/tokhash_lane.sv
module tokhash_lane #(
   parameter int LANE = 0,
   parameter int SEED = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic       restart,
   input  logic [7:0] din,
   output logic [7:0] state
);
   localparam logic [7:0] INIT = tokhash_pkg::lane_init(LANE, SEED);

   logic [7:0] st_q;
   logic [7:0] base;
   logic [7:0] nxt;

   always_comb begin
      base = restart ? INIT : st_q;
      nxt  = tokhash_pkg::pearson_entry(LANE, SEED, base ^ din);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    st_q <= INIT;
      else if (step) st_q <= nxt;
   end

   assign state = st_q;
endmodule

// File: rtl/tokhash_seq.sv
module tokhash_seq #(
   parameter int LEN_BYTES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [7:0] in_byte,
   input  logic       in_first,
   input  logic       in_last,
   output logic       in_ready,
   output logic       lane_step,
   output logic       lane_restart,
   output logic [7:0] lane_din,
   output logic       out_valid,
   output logic       take_last
);
   localparam int LEN_W = 8 * LEN_BYTES;
   localparam int PH_W  = $clog2(LEN_BYTES + 1);
   localparam logic [PH_W-1:0] LAST_PH = PH_W'(LEN_BYTES);

   logic [PH_W-1:0]  phase_q;
   logic [LEN_W-1:0] len_q;
   logic             open_q;
   logic             valid_q;
   logic             take;
   logic [LEN_W-1:0] len_sh;

   always_comb begin
      in_ready     = (phase_q == '0);
      take         = in_valid && in_ready && (in_first || open_q);
      take_last    = take && in_last;
      lane_step    = take || (phase_q != '0);
      lane_restart = take && in_first;
      len_sh       = len_q >> (8 * (LEN_BYTES - int'(phase_q)));
      lane_din     = (phase_q == '0) ? in_byte : len_sh[7:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         len_q   <= '0;
         open_q  <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= (phase_q == LAST_PH);
         if (take) begin
            len_q <= in_first ? LEN_W'(1) : len_q + LEN_W'(1);
            if (in_last) begin
               open_q  <= 1'b0;
               phase_q <= PH_W'(1);
            end else begin
               open_q  <= 1'b1;
            end
         end else if (phase_q != '0) begin
            phase_q <= (phase_q == LAST_PH) ? '0 : phase_q + PH_W'(1);
         end
      end
   end

   assign out_valid = valid_q;
endmodule

// File: rtl/tokhash_pearson.sv
module tokhash_pearson #(
   parameter int NUM_HASH       = 3,
   parameter int LANES_PER_HASH = 4,
   parameter int LEN_BYTES      = 2,
   parameter int SEED           = 8'h5A
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                in_valid,
   input  logic [7:0]                          in_byte,
   input  logic                                in_first,
   input  logic                                in_last,
   output logic                                in_ready,
   output logic                                out_valid,
   output logic [NUM_HASH*LANES_PER_HASH*8-1:0] out_hash
);
   localparam int NUM_LANES = NUM_HASH * LANES_PER_HASH;

   if (NUM_HASH < 1) begin : g_bad_hash
      $error("NUM_HASH must be at least 1");
   end
   if (LANES_PER_HASH < 1) begin : g_bad_lanes
      $error("LANES_PER_HASH must be at least 1");
   end
   if (LEN_BYTES < 1 || LEN_BYTES > 4) begin : g_bad_len
      $error("LEN_BYTES must lie in 1..4");
   end
   if (SEED < 0 || SEED > 255) begin : g_bad_seed
      $error("SEED must fit in one byte");
   end

   logic       lane_step;
   logic       lane_restart;
   logic [7:0] lane_din;
   logic       take_last;

   tokhash_seq #(.LEN_BYTES(LEN_BYTES)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_byte      (in_byte),
      .in_first     (in_first),
      .in_last      (in_last),
      .in_ready     (in_ready),
      .lane_step    (lane_step),
      .lane_restart (lane_restart),
      .lane_din     (lane_din),
      .out_valid    (out_valid),
      .take_last    (take_last)
   );

   for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
      tokhash_lane #(.LANE(k), .SEED(SEED)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .step    (lane_step),
         .restart (lane_restart),
         .din     (lane_din),
         .state   (out_hash[k*8 +: 8])
      );
   end
endmodule

// File: rtl/tokhash_chk.sv
module tokhash_chk #(
   parameter int LEN_BYTES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic in_ready,
   input logic out_valid,
   input logic take_last
);
   // R5
   stall_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_last |=> !in_ready);

   // R5
   stall_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ready) |=> !in_ready);

   if (LEN_BYTES == 2) begin : g_two
      // R5
      stall_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!in_ready && $past(!in_ready)) |=> in_ready);
   end

   // R6
   pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R6
   valid_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(!in_ready) && in_ready));
endmodule

bind tokhash_pearson tokhash_chk #(.LEN_BYTES(LEN_BYTES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .take_last (take_last)
);

// File: tb/sim_tokhash_pearson.sv
module sim_tokhash_pearson;
   localparam int CLK_P  = 10;
   localparam int NH     = 3;
   localparam int NL     = NH * 4;
   localparam int HW     = NL * 8;
   localparam int SEED_V = 8'h5A;
   localparam int WD_LIM = 150000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [7:0]    in_byte = 8'h00;
   logic          in_first = 1'b0;
   logic          in_last = 1'b0;
   logic          in_ready;
   logic          out_valid;
   logic [HW-1:0] out_hash;

   int    n_run = 0;
   int    n_bad = 0;
   bit    done = 0;
   string cur_tag = "R2 R3 R4";

   // reference model state
   int ph_m = 0;
   bit open_m = 0;
   int len_m = 0;
   bit val_m = 0;
   int lanes_m [NL];

   always #(CLK_P/2) clk = ~clk;

   tokhash_pearson u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_first(in_first), .in_last(in_last), .in_ready(in_ready),
      .out_valid(out_valid), .out_hash(out_hash)
   );

   function automatic int tab(int k, int x);
      int s, m, a, c;
      s = (SEED_V + 53 * k) % 256;
      m = (2 * (SEED_V / 2 + 19 * k) + 1) % 256;
      a = ((x ^ s) * m) % 256;
      c = a ^ (a / 8);
      return (167 * c + 71 * k + 3) % 256;
   endfunction

   task automatic check(bit ok, string tag, string what, logic [HW-1:0] act, logic [HW-1:0] exp);
      n_run++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic feed_all(int b);
      for (int k = 0; k < NL; k++) lanes_m[k] = tab(k, lanes_m[k] ^ b);
   endtask

   task automatic model_step(bit v, int b, bit f, bit l);
      bit nv;
      nv = (ph_m == 2);
      if (ph_m == 0) begin
         if (v && (f || open_m)) begin
            if (f) begin
               for (int k = 0; k < NL; k++) lanes_m[k] = tab(k, ((SEED_V ^ (29 * k + 7)) % 256) ^ b);
               len_m = 1;
            end else begin
               feed_all(b);
               len_m = (len_m + 1) % 65536;
            end
            open_m = !l;
            if (l) ph_m = 1;
         end
      end else if (ph_m == 1) begin
         feed_all(len_m / 256);
         ph_m = 2;
      end else begin
         feed_all(len_m % 256);
         ph_m = 0;
      end
      val_m = nv;
   endtask

   // Called at a falling edge: compare, drive, step model, advance one cycle.
   task automatic cyc(bit v, int b, bit f, bit l, output bit took);
      logic [HW-1:0] exp_h;
      check(in_ready == (ph_m == 0), "R5", "in_ready", HW'(in_ready), HW'(ph_m == 0));
      check(out_valid == val_m, "R6", "out_valid", HW'(out_valid), HW'(val_m));
      if (val_m) begin
         for (int k = 0; k < NL; k++) exp_h[k*8 +: 8] = 8'(lanes_m[k]);
         check(out_hash === exp_h, cur_tag, "out_hash", out_hash, exp_h);
      end
      took = (ph_m == 0) && v && (f || open_m);
      in_valid = v;
      in_byte  = 8'(b);
      in_first = f;
      in_last  = l;
      model_step(v, b, f, l);
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic put(int b, bit f, bit l);
      bit took = 0;
      while (!took) cyc(1, b, f, l, took);
   endtask

   task automatic send(string s, int gap);
      bit t;
      for (int i = 0; i < s.len(); i++) begin
         put(int'(s[i]), i == 0, i == s.len() - 1);
         if (i != s.len() - 1) for (int g = 0; g < gap; g++) cyc(0, 0, 0, 0, t);
      end
   endtask

   task automatic idle(int n);
      bit t;
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, t);
   endtask

   initial begin
      bit t;
      for (int k = 0; k < NL; k++) lanes_m[k] = 0;
      repeat (2) @(negedge clk);
      // R1: outputs while reset is held
      check(in_ready == 1'b1, "R1", "in_ready in reset", HW'(in_ready), HW'(1));
      check(out_valid == 1'b0, "R1", "out_valid in reset", HW'(out_valid), HW'(0));
      rst_n = 1'b1;
      // R1: first cycle after reset (compared inside cyc)
      idle(2);

      cur_tag = "R2 R3 R4";
      send("select", 0);
      send("where", 0);
      idle(4);

      cur_tag = "R11 R5";
      send("a", 0);
      send("b", 0);
      send("a", 0);
      idle(4);

      cur_tag = "R10";
      send("drop", 2);
      idle(4);

      cur_tag = "R7";
      cyc(1, int'("d"), 1, 0, t);
      cyc(1, int'("r"), 0, 0, t);
      send("union", 0);
      idle(4);

      cur_tag = "R8";
      cyc(1, int'("z"), 0, 0, t);
      cyc(1, int'("q"), 0, 1, t);
      send("or", 1);
      idle(4);

      cur_tag = "R9";
      put(int'("x"), 1, 0);
      for (int i = 1; i < 65536; i++) put(int'("x"), 0, 0);
      put(int'("x"), 0, 1);
      idle(5);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      repeat (WD_LIM) @(posedge clk);
      if (!done) begin
         n_run++;
         n_bad++;
         $display("FAIL R5 watchdog: actual %0d cycles expected fewer than %0d", WD_LIM, WD_LIM);
         $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   end
endmodule